// File: doc/BRIEF.md
# Capture/Compare/PWM Unit

This block is one timing channel that sits beside a free-running 16-bit timer and an 8-bit period timer. A 4-bit mode field in its control register selects what it does. In capture mode it stores the 16-bit timer value when chosen events occur on an input pin. In compare mode it watches for the timer to equal a stored 16-bit value and then acts on an output pin, raises an interrupt flag, or fires a trigger that clears the timer. In pulse-width mode it produces a 10-bit-resolution waveform whose period is set by the 8-bit period timer.

Software programs the unit through a 2-bit-address byte write port. Both timers are outside the block: it only reads their counts and the period timer's match strobe, and it asks for a clear of the 16-bit timer through its `tmr_clr` output. The stored 16-bit value is visible on `cmp_val`.

The unit is organised as a four-state machine held in `state_q`: IDLE_OFF, CAPTURE, COMPARE and PWM. The only transition is a write to the control register. That write moves the machine to the state named by mode bits 3:2 (00 IDLE_OFF, 01 CAPTURE, 10 COMPARE, 11 PWM), from any state to any state. A control write that changes the mode field is a restart. A restart reinitialises the prescaler, the match history, the PWM engine and the compare pin level.

Top module: `ccp_unit`

## Requirements
- R1: While reset is low and after it is released: `out_pin`, `int_flag`, `irq`, `evt_trig` and `tmr_clr` are 0, `cmp_val` is 0 and the mode is 0000.
- R2: The write port decodes these addresses. Address 0 writes the low byte of the stored value and address 1 writes the high byte; `cmp_val` shows the new value after the write edge. Address 2 writes the control register: bits 3:0 are the mode and bits 5:4 are the duty fraction. Address 3 writes bit 0 as the interrupt enable, and a 1 in bit 1 clears the flag.
- R3: Mode 0000, and the reserved modes 0001 to 0011, keep `out_pin` low. In these modes pin events and timer matches neither set the flag nor change the stored value.
- R4: Mode 0100 captures on a falling edge of `cap_pin` and mode 0101 on a rising edge. At the clock edge that first samples the new pin level, the timer count is stored and the flag is set.
- R5: Mode 0110 captures on every 4th rising edge and mode 0111 on every 16th rising edge.
- R6: A restart clears the capture edge counter, so the count of edges starts again from zero in the new mode.
- R7: In mode 1000 a match drives `out_pin` high, and in mode 1001 a match drives it low. Either match sets the flag. A match acts only in the first cycle the timer equals the stored value.
- R8: In mode 1010 a match sets only the flag, and `out_pin` keeps its level.
- R9: In mode 1011 a match sets the flag and gives a one-cycle pulse on both `evt_trig` and `tmr_clr`.
- R10: `irq` is high exactly when the flag and the enable bit are both 1.
- R11: In modes 11xx, a cycle with `per_match` high starts a new period. At that edge the unit loads the duty {low byte, control bits 5:4} into a buffer and drives `out_pin` high, unless that duty is zero. A duty change therefore takes effect only from the next period.
- R12: A 2-bit sub-count is zeroed at each period start and advances every clock. The PWM output goes low at the edge where {`per_cnt`, sub-count} + 1 reaches the buffered duty, so the output is high for as many cycles as the duty value, up to the full period.
- R13: A restart drives `out_pin` low on the next edge, except that entering mode 1001 drives it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| tmr_cnt | input | 16 | Count of the 16-bit time base |
| per_cnt | input | 8 | Count of the 8-bit period timer |
| per_match | input | 1 | Period timer reached its period |
| cap_pin | input | 1 | Capture event input |
| out_pin | output | 1 | Compare/PWM output |
| int_flag | output | 1 | Unit interrupt flag |
| irq | output | 1 | Enabled interrupt request |
| evt_trig | output | 1 | Special-event pulse |
| tmr_clr | output | 1 | Request to clear the 16-bit timer |
| cmp_val | output | 16 | Stored capture/compare value |

## Verification
Every result in this block is registered once. A captured value and its flag appear after the first clock edge that samples the new pin level. A compare action, its flag and the event pulse appear after the first edge at which the timer equals the stored value. A PWM level change appears after the period-start edge or the duty-reach edge. The bench drives all inputs at the falling clock edge and steps a behavioural model at the rising edge. It compares every output with the model at each following falling edge. Directed checks use precomputed values, such as the captured count or the number of high cycles in a period, and sample at the falling edge just after the edge that is due to produce the result.

// File: rtl/ccp_pkg.sv
package ccp_pkg;

    // Functional state, encoded as mode bits 3:2.
    typedef enum logic [1:0] {
        ST_OFF = 2'd0,
        ST_CAP = 2'd1,
        ST_CMP = 2'd2,
        ST_PWM = 2'd3
    } ccp_state_e;

    localparam int MODE_W = 4;

    localparam logic [1:0] ADR_VLO = 2'd0;
    localparam logic [1:0] ADR_VHI = 2'd1;
    localparam logic [1:0] ADR_CTL = 2'd2;
    localparam logic [1:0] ADR_IEN = 2'd3;

    // Compare sub-modes (mode bits 1:0).
    localparam logic [1:0] CMP_SET  = 2'b00;
    localparam logic [1:0] CMP_CLR  = 2'b01;
    localparam logic [1:0] CMP_SOFT = 2'b10;
    localparam logic [1:0] CMP_EVT  = 2'b11;

    localparam logic [MODE_W-1:0] MODE_CMP_CLR = 4'b1001;

    function automatic ccp_state_e mode_to_state(input logic [MODE_W-1:0] m);
        return ccp_state_e'(m[MODE_W-1:MODE_W-2]);
    endfunction

endpackage

// File: rtl/ccp_cap_edge.sv
module ccp_cap_edge #(
    parameter int SHORT_DIV = 4,
    parameter int LONG_DIV  = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       restart,
    input  logic [1:0] sel,
    input  logic       pin,
    output logic       hit
);
    localparam int PRE_W = $clog2(LONG_DIV);
    localparam logic [PRE_W-1:0] SHORT_LAST = PRE_W'(SHORT_DIV - 1);
    localparam logic [PRE_W-1:0] LONG_LAST  = PRE_W'(LONG_DIV - 1);

    logic             pin_q;
    logic [PRE_W-1:0] pre_q;
    logic             rise;
    logic             fall;

    assign rise = pin & ~pin_q;
    assign fall = ~pin & pin_q;

    always_comb begin
        unique case (sel)
            2'b00: hit = active & fall;
            2'b01: hit = active & rise;
            2'b10: hit = active & rise & (pre_q == SHORT_LAST);
            2'b11: hit = active & rise & (pre_q == LONG_LAST);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
            pre_q <= '0;
        end else begin
            pin_q <= pin;
            if (restart || !active) begin
                pre_q <= '0;
            end else if (rise && sel[1]) begin
                pre_q <= hit ? '0 : pre_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ccp_cmp_match.sv
module ccp_cmp_match
    import ccp_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          restart,
    input  logic          init_level,
    input  logic [1:0]    sel,
    input  logic [TW-1:0] tmr,
    input  logic [TW-1:0] ref_val,
    output logic          hit,
    output logic          lvl,
    output logic          evt
);
    logic match;
    logic match_q;

    assign match = (tmr == ref_val);
    assign hit   = active & match & ~match_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_q <= 1'b0;
            lvl     <= 1'b0;
            evt     <= 1'b0;
        end else if (restart) begin
            match_q <= 1'b0;
            lvl     <= init_level;
            evt     <= 1'b0;
        end else if (!active) begin
            match_q <= 1'b0;
            lvl     <= 1'b0;
            evt     <= 1'b0;
        end else begin
            match_q <= match;
            evt     <= hit && (sel == CMP_EVT);
            if (hit && sel == CMP_SET) begin
                lvl <= 1'b1;
            end else if (hit && sel == CMP_CLR) begin
                lvl <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ccp_pwm_gen.sv
module ccp_pwm_gen #(
    parameter int PW = 8,
    parameter int FW = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             restart,
    input  logic [PW+FW-1:0] duty_next,
    input  logic [PW-1:0]    per_cnt,
    input  logic             per_match,
    output logic             lvl
);
    localparam int DW = PW + FW;

    logic [FW-1:0] sub_q;
    logic [DW-1:0] buf_q;
    logic [DW:0]   fine_nx;

    assign fine_nx = {1'b0, per_cnt, sub_q} + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub_q <= '0;
            buf_q <= '0;
            lvl   <= 1'b0;
        end else if (restart || !active) begin
            sub_q <= '0;
            buf_q <= '0;
            lvl   <= 1'b0;
        end else if (per_match) begin
            sub_q <= '0;
            buf_q <= duty_next;
            lvl   <= (duty_next != '0);
        end else begin
            sub_q <= sub_q + 1'b1;
            if (fine_nx >= {1'b0, buf_q}) begin
                lvl <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ccp_unit.sv
module ccp_unit
    import ccp_pkg::*;
#(
    parameter int TW        = 16,
    parameter int PW        = 8,
    parameter int FW        = 2,
    parameter int SHORT_DIV = 4,
    parameter int LONG_DIV  = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [TW-1:0] tmr_cnt,
    input  logic [PW-1:0] per_cnt,
    input  logic          per_match,
    input  logic          cap_pin,
    output logic          out_pin,
    output logic          int_flag,
    output logic          irq,
    output logic          evt_trig,
    output logic          tmr_clr,
    output logic [TW-1:0] cmp_val
);
    localparam int BW = 8;
    localparam int HW = TW - BW;
    localparam int DW = PW + FW;

    ccp_state_e        state_q;
    logic [MODE_W-1:0] mode_q;
    logic [FW-1:0]     dlsb_q;
    logic [BW-1:0]     val_lo;
    logic [HW-1:0]     val_hi;
    logic              ien_q;
    logic              flag_q;

    logic              ctl_wr;
    logic              restart;
    logic              cmp_init;
    logic              cap_hit;
    logic              cmp_hit;
    logic              cmp_lvl;
    logic              cmp_evt;
    logic              pwm_lvl;
    logic [DW-1:0]     duty_next;

    assign ctl_wr    = wr_en && (wr_addr == ADR_CTL);
    assign restart   = ctl_wr && (wr_data[MODE_W-1:0] != mode_q);
    assign cmp_init  = (wr_data[MODE_W-1:0] == MODE_CMP_CLR);
    assign duty_next = {val_lo[PW-1:0], dlsb_q};

    ccp_cap_edge #(
        .SHORT_DIV (SHORT_DIV),
        .LONG_DIV  (LONG_DIV)
    ) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (state_q == ST_CAP),
        .restart (restart),
        .sel     (mode_q[1:0]),
        .pin     (cap_pin),
        .hit     (cap_hit)
    );

    ccp_cmp_match #(
        .TW (TW)
    ) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (state_q == ST_CMP),
        .restart    (restart),
        .init_level (cmp_init),
        .sel        (mode_q[1:0]),
        .tmr        (tmr_cnt),
        .ref_val    ({val_hi, val_lo}),
        .hit        (cmp_hit),
        .lvl        (cmp_lvl),
        .evt        (cmp_evt)
    );

    ccp_pwm_gen #(
        .PW (PW),
        .FW (FW)
    ) u_pwm (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (state_q == ST_PWM),
        .restart   (restart),
        .duty_next (duty_next),
        .per_cnt   (per_cnt),
        .per_match (per_match),
        .lvl       (pwm_lvl)
    );

    // State register: moves only on a control write.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else if (ctl_wr) begin
            state_q <= mode_to_state(wr_data[MODE_W-1:0]);
        end
    end

    // Output selection per state.
    always_comb begin
        unique case (state_q)
            ST_OFF: out_pin = 1'b0;
            ST_CAP: out_pin = 1'b0;
            ST_CMP: out_pin = cmp_lvl;
            ST_PWM: out_pin = pwm_lvl;
        endcase
    end

    // Register file, capture load and flag.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            dlsb_q <= '0;
            val_lo <= '0;
            val_hi <= '0;
            ien_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (wr_en && wr_addr == ADR_VLO) val_lo <= wr_data;
            if (wr_en && wr_addr == ADR_VHI) val_hi <= wr_data[HW-1:0];
            if (ctl_wr) begin
                mode_q <= wr_data[MODE_W-1:0];
                dlsb_q <= wr_data[MODE_W +: FW];
            end
            if (wr_en && wr_addr == ADR_IEN) ien_q <= wr_data[0];
            if (cap_hit) begin
                val_lo <= tmr_cnt[BW-1:0];
                val_hi <= tmr_cnt[TW-1:BW];
            end
            if (cap_hit || cmp_hit) begin
                flag_q <= 1'b1;
            end else if (wr_en && wr_addr == ADR_IEN && wr_data[1]) begin
                flag_q <= 1'b0;
            end
        end
    end

    assign int_flag = flag_q;
    assign irq      = flag_q & ien_q;
    assign evt_trig = cmp_evt;
    assign tmr_clr  = cmp_evt;
    assign cmp_val  = {val_hi, val_lo};

endmodule

// File: rtl/ccp_unit_chk.sv
module ccp_unit_chk #(
    parameter int DW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [1:0]    wr_addr,
    input logic [3:0]    wr_data,
    input logic [3:0]    mode_q,
    input logic [DW-1:0] duty_next,
    input logic          per_match,
    input logic          cap_hit,
    input logic          out_pin,
    input logic          int_flag,
    input logic          irq,
    input logic          evt_trig
);

    // R3
    off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[3:2] == 2'b00) |-> (!out_pin && !evt_trig));

    // R4
    cap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_hit |=> int_flag);

    // R9
    evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_trig |=> !evt_trig);

    // R9
    evt_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_trig |-> int_flag);

    // R10
    irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> int_flag);

    // R11
    pwm_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[3:2] == 2'b11 && per_match && duty_next == '0) |=> !out_pin);

    // R13
    restart_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd2 && wr_data != mode_q && wr_data != 4'b1001)
        |=> !out_pin);

endmodule

bind ccp_unit ccp_unit_chk #(.DW(DW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data[3:0]),
    .mode_q    (mode_q),
    .duty_next (duty_next),
    .per_match (per_match),
    .cap_hit   (cap_hit),
    .out_pin   (out_pin),
    .int_flag  (int_flag),
    .irq       (irq),
    .evt_trig  (evt_trig)
);

// File: tb/test_ccp_unit.sv
module test_ccp_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [15:0] tmr_cnt = '0;
    logic [7:0]  per_cnt;
    logic        per_match;
    logic        cap_pin = 1'b0;
    logic        out_pin, int_flag, irq, evt_trig, tmr_clr;
    logic [15:0] cmp_val;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit chk_on = 1'b0;
    string cur_req = "R1";

    // period timer stimulus
    bit pwm_run = 1'b0;
    int pr = 3;
    int ph = 0;
    int per = 0;

    ccp_unit i_ccp_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tmr_cnt(tmr_cnt), .per_cnt(per_cnt),
        .per_match(per_match), .cap_pin(cap_pin), .out_pin(out_pin),
        .int_flag(int_flag), .irq(irq), .evt_trig(evt_trig),
        .tmr_clr(tmr_clr), .cmp_val(cmp_val)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    assign per_cnt   = 8'(per);
    assign per_match = pwm_run && (per == pr) && (ph == 3);

    always @(negedge clk) begin
        if (!pwm_run) begin
            ph = 0;
            per = 0;
        end else if (ph == 3) begin
            ph = 0;
            per = (per == pr) ? 0 : per + 1;
        end else begin
            ph = ph + 1;
        end
    end

    // ---------------- behavioural reference model ----------------
    int m_mode, m_dl, m_lo, m_hi, m_ien, m_flag;
    int m_pinq, m_pre, m_mq, m_cout, m_evt, m_pout, m_dbuf, m_sub;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_dl = 0; m_lo = 0; m_hi = 0; m_ien = 0; m_flag = 0;
            m_pinq = 0; m_pre = 0; m_mq = 0; m_cout = 0; m_evt = 0;
            m_pout = 0; m_dbuf = 0; m_sub = 0;
        end else begin : step
            int c, sel, val, fine, dn, tv;
            bit rst_ev, rise, fall, capf, hit, match;
            int n_pre, n_mq, n_cout, n_evt, n_pout, n_dbuf, n_sub, n_flag;
            c = m_mode / 4;
            sel = m_mode % 4;
            tv = int'(tmr_cnt);
            val = m_hi * 256 + m_lo;
            rst_ev = wr_en && wr_addr == 2 && int'(wr_data[3:0]) != m_mode;
            rise = cap_pin && m_pinq == 0;
            fall = !cap_pin && m_pinq == 1;
            case (sel)
                0: capf = (c == 1) && fall;
                1: capf = (c == 1) && rise;
                2: capf = (c == 1) && rise && m_pre == 3;
                default: capf = (c == 1) && rise && m_pre == 15;
            endcase
            match = (tv == val);
            hit = (c == 2) && match && m_mq == 0;
            fine = int'(per_cnt) * 4 + m_sub;
            dn = m_lo * 4 + m_dl;

            if (rst_ev || c != 1) n_pre = 0;
            else if (rise && sel >= 2) n_pre = capf ? 0 : (m_pre + 1) % 16;
            else n_pre = m_pre;

            if (rst_ev) begin
                n_mq = 0; n_evt = 0;
                n_cout = (wr_data[3:0] == 4'b1001) ? 1 : 0;
            end else if (c != 2) begin
                n_mq = 0; n_evt = 0; n_cout = 0;
            end else begin
                n_mq = match ? 1 : 0;
                n_evt = (hit && sel == 3) ? 1 : 0;
                n_cout = (hit && sel == 0) ? 1 : (hit && sel == 1) ? 0 : m_cout;
            end

            if (rst_ev || c != 3) begin
                n_pout = 0; n_dbuf = 0; n_sub = 0;
            end else if (per_match) begin
                n_pout = (dn != 0) ? 1 : 0; n_dbuf = dn; n_sub = 0;
            end else begin
                n_sub = (m_sub + 1) % 4;
                n_dbuf = m_dbuf;
                n_pout = (fine + 1 >= m_dbuf) ? 0 : m_pout;
            end

            n_flag = m_flag;
            if (wr_en && wr_addr == 3 && wr_data[1]) n_flag = 0;
            if (capf || hit) n_flag = 1;

            if (wr_en && wr_addr == 0) m_lo = int'(wr_data);
            if (wr_en && wr_addr == 1) m_hi = int'(wr_data);
            if (wr_en && wr_addr == 2) begin
                m_mode = int'(wr_data[3:0]);
                m_dl = int'(wr_data[5:4]);
            end
            if (wr_en && wr_addr == 3) m_ien = wr_data[0] ? 1 : 0;
            if (capf) begin
                m_lo = tv % 256;
                m_hi = tv / 256;
            end
            m_pinq = cap_pin ? 1 : 0;
            m_pre = n_pre; m_mq = n_mq; m_cout = n_cout; m_evt = n_evt;
            m_pout = n_pout; m_dbuf = n_dbuf; m_sub = n_sub; m_flag = n_flag;
        end
    end

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h (t=%0t)",
                     req, what, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && chk_on) begin : cmpm
            int e_out;
            e_out = (m_mode / 4 == 3) ? m_pout : (m_mode / 4 == 2) ? m_cout : 0;
            chk(cur_req, "out_pin", out_pin, e_out);
            chk(cur_req, "int_flag", int_flag, m_flag);
            chk("R10", "irq", irq, m_flag & m_ien);
            chk(cur_req, "evt_trig", evt_trig, m_evt);
            chk(cur_req, "tmr_clr", tmr_clr, m_evt);
            chk(cur_req, "cmp_val", cmp_val, m_hi * 256 + m_lo);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc >= WDOG_LIMIT) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic pulses(input int n, input int base);
        for (int i = 0; i < n; i++) begin
            tmr_cnt = 16'(base + i);
            cap_pin = 1'b1;
            tick(1);
            cap_pin = 1'b0;
            tick(1);
        end
    endtask

    task automatic count_high(output int cnt);
        cnt = 0;
        for (int i = 0; i < 16; i++) begin
            tick(1);
            if (out_pin) cnt++;
        end
    endtask

    initial begin
        int highs;
        tick(3);
        cur_req = "R1";
        chk("R1", "out_pin", out_pin, 0);
        chk("R1", "int_flag", int_flag, 0);
        chk("R1", "irq", irq, 0);
        chk("R1", "evt_trig", evt_trig, 0);
        chk("R1", "tmr_clr", tmr_clr, 0);
        chk("R1", "cmp_val", cmp_val, 0);
        rst_n = 1'b1;
        chk_on = 1'b1;
        tick(1);

        cur_req = "R2";
        wr(2'd0, 8'h34);
        wr(2'd1, 8'h12);
        chk("R2", "cmp_val", cmp_val, 16'h1234);

        cur_req = "R3";
        tmr_cnt = 16'h1234;
        tick(2);
        cap_pin = 1'b1; tick(1); cap_pin = 1'b0; tick(1);
        chk("R3", "int_flag off", int_flag, 0);
        chk("R3", "cmp_val off", cmp_val, 16'h1234);
        wr(2'd2, 8'h02);
        cap_pin = 1'b1; tick(1); cap_pin = 1'b0; tick(2);
        chk("R3", "int_flag reserved", int_flag, 0);
        chk("R3", "out_pin reserved", out_pin, 0);

        cur_req = "R4";
        wr(2'd3, 8'h01);
        wr(2'd2, 8'h04);
        tmr_cnt = 16'h0AB0; cap_pin = 1'b1; tick(2);
        chk("R4", "no capture on rise", int_flag, 0);
        tmr_cnt = 16'h0AB5; cap_pin = 1'b0; tick(1);
        chk("R4", "fall capture", cmp_val, 16'h0AB5);
        chk("R4", "flag", int_flag, 1);
        chk("R10", "irq enabled", irq, 1);
        wr(2'd3, 8'h03);
        chk("R2", "flag cleared", int_flag, 0);
        wr(2'd3, 8'h00);
        wr(2'd2, 8'h05);
        tmr_cnt = 16'h0C01; cap_pin = 1'b1; tick(1);
        chk("R4", "rise capture", cmp_val, 16'h0C01);
        chk("R10", "irq masked", irq, 0);
        cap_pin = 1'b0; tick(1);
        wr(2'd3, 8'h02);

        cur_req = "R5";
        wr(2'd2, 8'h06);
        pulses(3, 16'h0100);
        chk("R5", "no capture after 3", int_flag, 0);
        pulses(1, 16'h0103);
        chk("R5", "4th edge capture", cmp_val, 16'h0103);
        wr(2'd3, 8'h02);
        wr(2'd2, 8'h07);
        pulses(15, 16'h0200);
        chk("R5", "no capture after 15", int_flag, 0);
        pulses(1, 16'h020F);
        chk("R5", "16th edge capture", cmp_val, 16'h020F);

        cur_req = "R6";
        wr(2'd3, 8'h02);
        wr(2'd2, 8'h06);
        pulses(2, 16'h0300);
        wr(2'd2, 8'h07);
        pulses(14, 16'h0400);
        chk("R6", "counter restarted", int_flag, 0);
        pulses(2, 16'h040E);
        chk("R6", "16th after restart", cmp_val, 16'h040F);

        cur_req = "R7";
        tmr_cnt = 16'h0000;
        wr(2'd2, 8'h08);
        wr(2'd0, 8'h50);
        wr(2'd1, 8'h00);
        wr(2'd3, 8'h02);
        for (int i = 0; i <= 16; i++) begin
            tmr_cnt = 16'(16'h0040 + i);
            tick(1);
        end
        chk("R7", "set on match", out_pin, 1);
        chk("R7", "flag on match", int_flag, 1);
        tick(2);
        wr(2'd3, 8'h02);
        tick(3);
        chk("R7", "single fire", int_flag, 0);
        cur_req = "R13";
        wr(2'd2, 8'h09);
        chk("R13", "clear mode starts high", out_pin, 1);
        cur_req = "R7";
        tmr_cnt = 16'h0041; tick(1);
        tmr_cnt = 16'h0050; tick(1);
        chk("R7", "clear on match", out_pin, 0);
        chk("R7", "flag clear mode", int_flag, 1);
        wr(2'd3, 8'h02);

        cur_req = "R8";
        wr(2'd2, 8'h0A);
        tick(2);
        chk("R8", "out unchanged", out_pin, 0);
        chk("R8", "flag only", int_flag, 1);
        chk("R8", "no event", evt_trig, 0);

        cur_req = "R9";
        wr(2'd3, 8'h02);
        tmr_cnt = 16'h0041;
        wr(2'd2, 8'h0B);
        tick(1);
        tmr_cnt = 16'h0050; tick(1);
        chk("R9", "evt pulse", evt_trig, 1);
        chk("R9", "timer clear", tmr_clr, 1);
        tick(1);
        chk("R9", "evt one cycle", evt_trig, 0);

        cur_req = "R12";
        wr(2'd0, 8'h02);
        wr(2'd2, 8'h1C);
        pwm_run = 1'b1;
        tick(40);
        count_high(highs);
        chk("R12", "high cycles duty 9", highs, 9);
        cur_req = "R11";
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h0C);
        tick(20);
        count_high(highs);
        chk("R11", "high cycles duty 0", highs, 0);
        wr(2'd0, 8'hFF);
        tick(20);
        count_high(highs);
        chk("R11", "high cycles full duty", highs, 16);
        wr(2'd0, 8'h01);
        tick(20);
        count_high(highs);
        chk("R12", "high cycles duty 4", highs, 4);

        cur_req = "R13";
        wr(2'd2, 8'h00);
        chk("R13", "restart to off", out_pin, 0);
        pwm_run = 1'b0;
        tick(3);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule